// File: doc/BRIEF.md
# Program Sequencer with Branch Modes

This block works out the program counter that follows the current instruction of a byte-addressed processor with a 12-bit code space. On every step strobe it takes the current address, a decoded branch kind, the immediate fields and the condition inputs. It registers the next address and a taken indication.

It supports several ways to change the address:
- a plain advance by the instruction length;
- an absolute load of a 12-bit target;
- a signed 8-bit relative branch;
- a forward skip over up to three following opcodes of given lengths;
- conditional loads and branches on one of four flags, in either polarity;
- a jump on the value of one bit of a 24-bit register word;
- a fixed entry jump to user code at address 48;
- a subroutine call and return through a four-deep return-address stack.

Instruction decode, the ALU and the memories sit outside the block. The stack depth and a sticky misuse flag are visible at the ports.

Top module: `prog_sequencer`

## Requirements
- R1: A synchronous reset sets next_pc to 0, taken to 0, stk_depth to 0 and stk_err to 0. Reset also clears stk_err after it has been set.
- R2: With kind = 1 (jump), the step loads abs_tgt into next_pc and sets taken.
- R3: With kind = 2 (relative branch), next_pc becomes cur_pc plus rel_off taken as a signed 8-bit value (-128 to +127). The sum wraps modulo 4096.
- R4: With kind = 3 (skip), next_pc becomes cur_pc + ilen plus the lengths of the first skip_cnt opcodes. Opcode i's length is the field skip_lens[3i+2:3i]. skip_cnt = 0 gives a plain advance with taken = 0.
- R5: Kinds 4 (absolute) and 5 (relative) are conditional. The flag is flags[flag_sel], where bit 0 = carry, 1 = overflow, 2 = sign and 3 = zero. The branch is taken when that flag equals cond_pol. Otherwise next_pc = cur_pc + ilen and taken = 0.
- R6: With kind = 6 (bit jump), next_pc becomes abs_tgt when test_word[bit_idx] equals cond_pol and bit_idx is 0 to 23. A bit_idx of 24 or more never branches.
- R7: With kind = 7 (call), the step pushes cur_pc + ilen, loads abs_tgt and raises stk_depth by one. The call ignores flags and cond_pol.
- R8: With kind = 8 (return), the step pops the newest stack entry into next_pc (last in, first out) and lowers stk_depth by one.
- R9: A call on a full stack (depth 4) still loads abs_tgt but leaves the stack unchanged. A return on an empty stack advances by ilen with taken = 0. Both set stk_err, which stays set until reset.
- R10: With kind = 9 (entry), the step loads address 48.
- R11: Kind 0 (or any unused kind) advances by ilen with taken = 0. While step is low, all outputs hold whatever the kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 1 | Compute and register the next address this cycle |
| cur_pc | input | 12 | Address of the current instruction |
| kind | input | 4 | Branch kind code (0 to 9) |
| ilen | input | 3 | Length of the current instruction in bytes |
| abs_tgt | input | 12 | Absolute target address |
| rel_off | input | 8 | Signed relative offset |
| skip_cnt | input | 2 | Number of following opcodes to skip (0 to 3) |
| skip_lens | input | 9 | Lengths of the three following opcodes, 3 bits each |
| flags | input | 4 | Condition flags: carry, overflow, sign, zero |
| flag_sel | input | 2 | Index of the flag tested |
| cond_pol | input | 1 | Flag or bit value that makes a branch taken |
| test_word | input | 24 | Register word for the bit jump |
| bit_idx | input | 5 | Bit index tested in test_word |
| next_pc | output | 12 | Registered next program counter |
| taken | output | 1 | Registered: last step left the sequential path |
| stk_depth | output | 3 | Number of entries in the return stack |
| stk_err | output | 1 | Sticky stack overflow/underflow flag |

## Verification
A stack misuse and an address load can land on the same step. A call on a full stack must still load its target while its push is refused and the error flag rises. A return on an empty stack must take the sequential path while the flag rises. The bench fills the stack with four nested calls and issues a fifth. It then drains the stack with four returns and issues one more. The scoreboard judges each of those cycles on the address, taken, depth and error flag together, so a refused push that also drops the jump is caught, and so is a correct jump that corrupts the depth.

// File: rtl/seq_pkg.sv
package seq_pkg;
  typedef enum logic [3:0] {
    K_ADV   = 4'd0,
    K_JMP   = 4'd1,
    K_BRA   = 4'd2,
    K_SKIP  = 4'd3,
    K_CJMP  = 4'd4,
    K_CBRA  = 4'd5,
    K_BITJ  = 4'd6,
    K_CALL  = 4'd7,
    K_RET   = 4'd8,
    K_ENTRY = 4'd9
  } kind_e;
endpackage

// File: rtl/seq_cond.sv
module seq_cond #(
  parameter int DW   = 24,
  parameter int IDXW = 5
) (
  input  logic [3:0]      flags,
  input  logic [1:0]      flag_sel,
  input  logic            pol,
  input  logic [DW-1:0]   word,
  input  logic [IDXW-1:0] idx,
  output logic            flag_hit,
  output logic            bit_hit
);
  localparam logic [IDXW:0] LIM = (IDXW+1)'(DW);

  logic sel_bit;
  logic idx_ok;

  always_comb begin
    sel_bit = 1'b0;
    for (int i = 0; i < DW; i++) begin
      if (idx == IDXW'(i)) sel_bit = word[i];
    end
  end

  assign idx_ok   = ({1'b0, idx} < LIM);
  assign flag_hit = (flags[flag_sel] == pol);
  assign bit_hit  = idx_ok && (sel_bit == pol);
endmodule

// File: rtl/seq_target.sv
module seq_target #(
  parameter int AW    = 12,
  parameter int OW    = 8,
  parameter int LW    = 3,
  parameter int SKIPN = 3,
  parameter int CW    = 2
) (
  input  logic [AW-1:0]       pc,
  input  logic [LW-1:0]       ilen,
  input  logic [OW-1:0]       off,
  input  logic [CW-1:0]       cnt,
  input  logic [SKIPN*LW-1:0] lens,
  output logic [AW-1:0]       adv,
  output logic [AW-1:0]       rel,
  output logic [AW-1:0]       skp
);
  logic [AW-1:0] part [SKIPN+1];

  assign adv     = pc + {{(AW-LW){1'b0}}, ilen};
  assign rel     = pc + {{(AW-OW){off[OW-1]}}, off};
  assign part[0] = adv;

  for (genvar g = 0; g < SKIPN; g++) begin : g_pref
    assign part[g+1] = part[g] + {{(AW-LW){1'b0}}, lens[g*LW +: LW]};
  end

  always_comb begin
    skp = part[0];
    for (int i = 1; i <= SKIPN; i++) begin
      if (cnt == CW'(i)) skp = part[i];
    end
  end
endmodule

// File: rtl/seq_retstack.sv
module seq_retstack #(
  parameter int AW    = 12,
  parameter int DEPTH = 4,
  parameter int PW    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic          pop,
  input  logic [AW-1:0] din,
  output logic [AW-1:0] top,
  output logic [PW-1:0] depth,
  output logic          full,
  output logic          empty
);
  localparam int AI = $clog2(DEPTH);

  logic [AW-1:0] mem [DEPTH];
  logic [PW-1:0] ptr;
  logic [PW-1:0] pm1;

  assign full  = (ptr == PW'(DEPTH));
  assign empty = (ptr == '0);
  assign pm1   = ptr - 1'b1;
  assign top   = empty ? '0 : mem[pm1[AI-1:0]];
  assign depth = ptr;

  always_ff @(posedge clk) begin
    if (push && !full) mem[ptr[AI-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst)                ptr <= '0;
    else if (push && !full) ptr <= ptr + 1'b1;
    else if (pop && !empty) ptr <= pm1;
  end
endmodule

// File: rtl/prog_sequencer.sv
module prog_sequencer
  import seq_pkg::*;
#(
  parameter int AW       = 12,
  parameter int OW       = 8,
  parameter int LW       = 3,
  parameter int SKIPN    = 3,
  parameter int DW       = 24,
  parameter int DEPTH    = 4,
  parameter int RESET_PC = 0,
  parameter int ENTRY_PC = 48,
  localparam int CW   = $clog2(SKIPN+1),
  localparam int IDXW = $clog2(DW),
  localparam int SW   = $clog2(DEPTH+1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                step,
  input  logic [AW-1:0]       cur_pc,
  input  logic [3:0]          kind,
  input  logic [LW-1:0]       ilen,
  input  logic [AW-1:0]       abs_tgt,
  input  logic [OW-1:0]       rel_off,
  input  logic [CW-1:0]       skip_cnt,
  input  logic [SKIPN*LW-1:0] skip_lens,
  input  logic [3:0]          flags,
  input  logic [1:0]          flag_sel,
  input  logic                cond_pol,
  input  logic [DW-1:0]       test_word,
  input  logic [IDXW-1:0]     bit_idx,
  output logic [AW-1:0]       next_pc,
  output logic                taken,
  output logic [SW-1:0]       stk_depth,
  output logic                stk_err
);
  logic          flag_hit, bit_hit;
  logic [AW-1:0] adv_a, rel_a, skp_a, stk_top;
  logic          stk_full, stk_empty;
  logic [AW-1:0] nxt_c;
  logic          tk_c, push_c, pop_c, err_c;

  seq_cond #(.DW(DW), .IDXW(IDXW)) u_cond (
    .flags(flags), .flag_sel(flag_sel), .pol(cond_pol),
    .word(test_word), .idx(bit_idx),
    .flag_hit(flag_hit), .bit_hit(bit_hit)
  );

  seq_target #(.AW(AW), .OW(OW), .LW(LW), .SKIPN(SKIPN), .CW(CW)) u_tgt (
    .pc(cur_pc), .ilen(ilen), .off(rel_off), .cnt(skip_cnt), .lens(skip_lens),
    .adv(adv_a), .rel(rel_a), .skp(skp_a)
  );

  seq_retstack #(.AW(AW), .DEPTH(DEPTH), .PW(SW)) u_stk (
    .clk(clk), .rst(rst), .push(push_c), .pop(pop_c), .din(adv_a),
    .top(stk_top), .depth(stk_depth), .full(stk_full), .empty(stk_empty)
  );

  always_comb begin
    nxt_c  = adv_a;
    tk_c   = 1'b0;
    push_c = 1'b0;
    pop_c  = 1'b0;
    err_c  = 1'b0;
    case (kind)
      K_JMP:   begin nxt_c = abs_tgt; tk_c = 1'b1; end
      K_BRA:   begin nxt_c = rel_a;   tk_c = 1'b1; end
      K_SKIP:  begin nxt_c = skp_a;   tk_c = (skip_cnt != '0); end
      K_CJMP:  if (flag_hit) begin nxt_c = abs_tgt; tk_c = 1'b1; end
      K_CBRA:  if (flag_hit) begin nxt_c = rel_a;   tk_c = 1'b1; end
      K_BITJ:  if (bit_hit)  begin nxt_c = abs_tgt; tk_c = 1'b1; end
      K_CALL: begin
        nxt_c = abs_tgt;
        tk_c  = 1'b1;
        if (stk_full) err_c = 1'b1;
        else          push_c = step;
      end
      K_RET: begin
        if (stk_empty) err_c = 1'b1;
        else begin
          pop_c = step;
          nxt_c = stk_top;
          tk_c  = 1'b1;
        end
      end
      K_ENTRY: begin nxt_c = AW'(ENTRY_PC); tk_c = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      next_pc <= AW'(RESET_PC);
      taken   <= 1'b0;
      stk_err <= 1'b0;
    end else if (step) begin
      next_pc <= nxt_c;
      taken   <= tk_c;
      if (err_c) stk_err <= 1'b1;
    end
  end
endmodule

// File: rtl/prog_sequencer_chk.sv
module prog_sequencer_chk
  import seq_pkg::*;
#(
  parameter int AW    = 12,
  parameter int DEPTH = 4,
  parameter int SW    = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          step,
  input logic [3:0]    kind,
  input logic [AW-1:0] abs_tgt,
  input logic [AW-1:0] next_pc,
  input logic          taken,
  input logic [SW-1:0] stk_depth,
  input logic          stk_err,
  input logic [AW-1:0] stk_top
);
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !step |=> ($stable(next_pc) && $stable(taken) && $stable(stk_depth) && $stable(stk_err)));

  p_jump_r2: assert property (@(posedge clk) disable iff (rst)
    (step && kind == K_JMP) |=> (next_pc == $past(abs_tgt) && taken));

  p_call_push_r7: assert property (@(posedge clk) disable iff (rst)
    (step && kind == K_CALL && stk_depth < SW'(DEPTH)) |=>
      (stk_depth == $past(stk_depth) + 1'b1 && next_pc == $past(abs_tgt)));

  p_ret_pop_r8: assert property (@(posedge clk) disable iff (rst)
    (step && kind == K_RET && stk_depth != '0) |=>
      (next_pc == $past(stk_top) && stk_depth == $past(stk_depth) - 1'b1));

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    stk_err |=> stk_err);

  p_full_call_r9: assert property (@(posedge clk) disable iff (rst)
    (step && kind == K_CALL && stk_depth == SW'(DEPTH)) |=>
      (stk_err && $stable(stk_depth)));

  p_depth_max_r9: assert property (@(posedge clk) disable iff (rst)
    stk_depth <= SW'(DEPTH));
endmodule

bind prog_sequencer prog_sequencer_chk #(.AW(AW), .DEPTH(DEPTH), .SW(SW)) u_chk (
  .clk(clk), .rst(rst), .step(step), .kind(kind), .abs_tgt(abs_tgt),
  .next_pc(next_pc), .taken(taken), .stk_depth(stk_depth),
  .stk_err(stk_err), .stk_top(stk_top)
);

// File: tb/sim_prog_sequencer.sv
module sim_prog_sequencer;
  typedef struct {
    logic [11:0] pc;
    logic        tk;
    logic [2:0]  dep;
    logic        err;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        step = 1'b0;
  logic [11:0] cur_pc = '0;
  logic [3:0]  kind = '0;
  logic [2:0]  ilen = '0;
  logic [11:0] abs_tgt = '0;
  logic [7:0]  rel_off = '0;
  logic [1:0]  skip_cnt = '0;
  logic [8:0]  skip_lens = '0;
  logic [3:0]  flags = '0;
  logic [1:0]  flag_sel = '0;
  logic        cond_pol = 1'b0;
  logic [23:0] test_word = '0;
  logic [4:0]  bit_idx = '0;
  logic [11:0] next_pc;
  logic        taken;
  logic [2:0]  stk_depth;
  logic        stk_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic issued = 1'b0;
  logic due = 1'b0;
  exp_t sb[$];

  logic [11:0] m_pc = 12'd0;
  logic        m_tk = 1'b0;
  logic        m_err = 1'b0;
  logic [11:0] m_stk[$];

  always #5 clk = ~clk;

  prog_sequencer u0 (
    .clk(clk), .rst(rst), .step(step), .cur_pc(cur_pc), .kind(kind), .ilen(ilen),
    .abs_tgt(abs_tgt), .rel_off(rel_off), .skip_cnt(skip_cnt), .skip_lens(skip_lens),
    .flags(flags), .flag_sel(flag_sel), .cond_pol(cond_pol), .test_word(test_word),
    .bit_idx(bit_idx), .next_pc(next_pc), .taken(taken), .stk_depth(stk_depth),
    .stk_err(stk_err)
  );

  always @(posedge clk) due <= issued;

  always @(negedge clk) begin
    if (due) begin
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard: no expected item, actual pc=%0d", next_pc);
      end else begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (next_pc !== e.pc || taken !== e.tk || stk_depth !== e.dep || stk_err !== e.err) begin
          errors++;
          $display("FAIL %s: actual pc=%0d tk=%0b dep=%0d err=%0b expected pc=%0d tk=%0b dep=%0d err=%0b",
                   e.tag, next_pc, taken, stk_depth, stk_err, e.pc, e.tk, e.dep, e.err);
        end
      end
    end
  end

  task automatic defaults();
    step = 1'b1; kind = 4'd0; ilen = 3'd1; abs_tgt = '0; rel_off = '0;
    skip_cnt = '0; skip_lens = '0; flags = '0; flag_sel = '0; cond_pol = 1'b0;
    test_word = '0; bit_idx = '0;
  endtask

  task automatic issue(input string tag);
    logic [11:0] adv, nx;
    logic tk;
    exp_t e;
    adv = cur_pc + 12'(ilen);
    nx = adv; tk = 1'b0;
    if (step) begin
      case (kind)
        4'd1: begin nx = abs_tgt; tk = 1'b1; end
        4'd2: begin nx = cur_pc + {{4{rel_off[7]}}, rel_off}; tk = 1'b1; end
        4'd3: begin
          for (int i = 0; i < 3; i++)
            if (i < int'(skip_cnt)) nx = nx + 12'(skip_lens[i*3 +: 3]);
          tk = (skip_cnt != 0);
        end
        4'd4: if (flags[flag_sel] == cond_pol) begin nx = abs_tgt; tk = 1'b1; end
        4'd5: if (flags[flag_sel] == cond_pol) begin
                nx = cur_pc + {{4{rel_off[7]}}, rel_off}; tk = 1'b1; end
        4'd6: if (bit_idx < 24 && test_word[bit_idx] == cond_pol) begin nx = abs_tgt; tk = 1'b1; end
        4'd7: begin
          nx = abs_tgt; tk = 1'b1;
          if (m_stk.size() == 4) m_err = 1'b1; else m_stk.push_back(adv);
        end
        4'd8: begin
          if (m_stk.size() == 0) m_err = 1'b1;
          else begin nx = m_stk.pop_back(); tk = 1'b1; end
        end
        4'd9: begin nx = 12'd48; tk = 1'b1; end
        default: ;
      endcase
      m_pc = nx; m_tk = tk;
    end
    e.pc = m_pc; e.tk = m_tk; e.dep = 3'(m_stk.size()); e.err = m_err; e.tag = tag;
    sb.push_back(e);
    issued = 1'b1;
    @(negedge clk);
  endtask

  task automatic direct(input string tag, input logic [11:0] pc, input logic tk,
                        input logic [2:0] dep, input logic err);
    checks++;
    if (next_pc !== pc || taken !== tk || stk_depth !== dep || stk_err !== err) begin
      errors++;
      $display("FAIL %s: actual pc=%0d tk=%0b dep=%0d err=%0b expected pc=%0d tk=%0b dep=%0d err=%0b",
               tag, next_pc, taken, stk_depth, stk_err, pc, tk, dep, err);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    direct("R1 reset state", 12'd0, 1'b0, 3'd0, 1'b0);
    rst = 1'b0;
    @(negedge clk);

    defaults(); cur_pc = 12'd100; ilen = 3'd2; issue("R11 advance");
    defaults(); cur_pc = 12'd100; kind = 4'd12; ilen = 3'd5; issue("R11 unused kind");
    defaults(); cur_pc = 12'd5; kind = 4'd1; abs_tgt = 12'hABC; issue("R2 jump");
    defaults(); step = 1'b0; cur_pc = 12'd7; kind = 4'd1; abs_tgt = 12'h123; issue("R11 hold");
    defaults(); cur_pc = 12'd10; kind = 4'd2; rel_off = 8'hEC; issue("R3 backward wrap");
    defaults(); cur_pc = 12'd4090; kind = 4'd2; rel_off = 8'd10; issue("R3 forward wrap");
    defaults(); cur_pc = 12'd1000; kind = 4'd2; rel_off = 8'h80; issue("R3 min offset");
    defaults(); cur_pc = 12'd1000; kind = 4'd2; rel_off = 8'h7F; issue("R3 max offset");
    defaults(); cur_pc = 12'd200; kind = 4'd3; skip_cnt = 2'd3; skip_lens = {3'd3, 3'd2, 3'd1}; issue("R4 skip three");
    defaults(); cur_pc = 12'd200; kind = 4'd3; skip_cnt = 2'd1; ilen = 3'd2; skip_lens = {3'd5, 3'd5, 3'd4}; issue("R4 skip one");
    defaults(); cur_pc = 12'd200; kind = 4'd3; skip_cnt = 2'd2; skip_lens = {3'd7, 3'd5, 3'd5}; issue("R4 skip two");
    defaults(); cur_pc = 12'd200; kind = 4'd3; skip_cnt = 2'd0; skip_lens = 9'h1FF; issue("R4 skip none");
    for (int s = 0; s < 4; s++) begin
      defaults(); cur_pc = 12'd300; kind = 4'd4; abs_tgt = 12'd900 + 12'(s);
      flag_sel = 2'(s); flags = 4'(1 << s); cond_pol = 1'b1; issue("R5 abs flag set taken");
      defaults(); cur_pc = 12'd300; kind = 4'd4; abs_tgt = 12'd900; ilen = 3'd3;
      flag_sel = 2'(s); flags = ~4'(1 << s); cond_pol = 1'b1; issue("R5 abs flag clear not taken");
    end
    defaults(); cur_pc = 12'd50; kind = 4'd5; rel_off = 8'hF0; flag_sel = 2'd3; cond_pol = 1'b0; issue("R5 rel zero clear taken");
    defaults(); cur_pc = 12'd50; kind = 4'd5; rel_off = 8'h20; ilen = 3'd2; flag_sel = 2'd1; flags = 4'b0010; cond_pol = 1'b0; issue("R5 rel not taken");
    defaults(); cur_pc = 12'd60; kind = 4'd6; abs_tgt = 12'd777; test_word = 24'h800000; bit_idx = 5'd23; cond_pol = 1'b1; ilen = 3'd3; issue("R6 bit 23 set");
    defaults(); cur_pc = 12'd60; kind = 4'd6; abs_tgt = 12'd778; test_word = 24'hFFFFDF; bit_idx = 5'd5; cond_pol = 1'b0; ilen = 3'd3; issue("R6 bit 5 clear");
    defaults(); cur_pc = 12'd60; kind = 4'd6; abs_tgt = 12'd779; test_word = 24'h000001; bit_idx = 5'd0; cond_pol = 1'b0; ilen = 3'd3; issue("R6 polarity miss");
    defaults(); cur_pc = 12'd60; kind = 4'd6; abs_tgt = 12'd780; test_word = 24'hFFFFFF; bit_idx = 5'd24; cond_pol = 1'b0; ilen = 3'd3; issue("R6 index 24 never");
    defaults(); kind = 4'd9; cur_pc = 12'd3000; issue("R10 entry");
    for (int c = 0; c < 4; c++) begin
      defaults(); kind = 4'd7; cur_pc = 12'd100 + 12'(c * 16); ilen = 3'd3;
      abs_tgt = 12'd2000 + 12'(c * 8); flags = 4'hF; cond_pol = 1'(c);
      issue("R7 call push");
    end
    defaults(); kind = 4'd7; cur_pc = 12'd400; ilen = 3'd3; abs_tgt = 12'd3333; issue("R9 call on full");
    for (int r = 0; r < 4; r++) begin
      defaults(); kind = 4'd8; cur_pc = 12'd2500; issue("R8 return LIFO");
    end
    defaults(); kind = 4'd8; cur_pc = 12'd2600; ilen = 3'd1; issue("R9 return on empty");
    defaults(); cur_pc = 12'd10; ilen = 3'd4; issue("R9 error sticky");
    step = 1'b0; issued = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    direct("R1 reset clears error", 12'd0, 1'b0, 3'd0, 1'b0);
    if (sb.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard: actual %0d items left expected 0", sb.size());
    end
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule